// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a serial memory protocol engine and a byte-wide nonvolatile array. After the protocol engine has decoded a write command and its 12-bit word address, it signals the start of a write. Each data byte that follows is stored in a 32-slot page latch. A per-slot loaded mask records which slots hold data. The slot index advances only in the low five address bits, so a long burst wraps around inside the addressed page and overwrites slots it already filled. Nothing reaches the array while bytes are being collected.

A STOP event ends the collection. If at least one byte was loaded and the protect input is low, the block enters a self-timed program cycle. It scans the 32 slots, writes one loaded slot per clock to the array, and holds `busy` high until a parameterised number of timebase ticks has elapsed. The protocol engine uses `busy` to withhold acknowledges. A repeated START during collection throws the latched data away. When collection ends, `last_ptr` holds the most recently loaded address. A current-address read that follows uses that address plus one.

The controller has four states. `ST_IDLE` moves to `ST_FILL` on `wr_start`. `ST_FILL` moves back to `ST_IDLE` on `restart_evt` (the discard path), or on `stop_evt` when no byte was loaded or `wp` is high. `ST_FILL` moves to `ST_PROG` on `stop_evt` when at least one byte was loaded and `wp` is low. `ST_PROG` moves to `ST_HOLD` once the slot scan reaches slot 31. `ST_HOLD` moves to `ST_IDLE` once the tick count reaches `WR_TICKS`.

Top module: `pwb_page_writer`

## Requirements
- R1: After reset, `busy` is 0, `arr_we` is 0 and `last_ptr` is 0.
- R2: Each data byte is stored at the page slot named by the low 5 bits of the current address. After every byte only those 5 bits increment, modulo 32. The upper 7 bits (the page) never change, so a burst that starts near the end of a page continues at slot 0 of the same page.
- R3: If more than 32 bytes arrive, the slots wrap and are overwritten. The array receives the last value sent for each slot.
- R4: Nothing is written to the array before STOP. A `stop_evt` seen in `ST_FILL` with at least one loaded byte and `wp` low makes `busy` read 1 from the next clock.
- R5: During the program cycle, each loaded slot is written exactly once, at address {page, slot}, one write per clock. Slots that were not loaded and all other pages keep their contents. `arr_we` is only ever high while `busy` is high.
- R6: `busy` stays high for at least the 32-clock slot scan and until `WR_TICKS` pulses of `tick` have been counted since STOP. It then returns to 0.
- R7: While `busy` is high, `wr_start`, `byte_vld` and `stop_evt` are ignored. They cause no writes and do not change `last_ptr`.
- R8: If `wp` is high when STOP arrives, the array is not written and `busy` stays 0.
- R9: A `restart_evt` during collection discards the latched bytes. No write and no busy period follow.
- R10: A STOP with no data byte after `wr_start` starts no program cycle.
- R11: On STOP or repeated START in `ST_FILL`, `last_ptr` takes the address of the last loaded byte (page and slot). If no byte was loaded, it takes the start address minus 1, modulo 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | One-cycle pulse: write command decoded, address valid |
| wr_addr | input | 12 | Word address of the first byte |
| byte_vld | input | 1 | One-cycle pulse: a data byte was received |
| byte_data | input | 8 | Received data byte |
| stop_evt | input | 1 | One-cycle pulse: STOP condition |
| restart_evt | input | 1 | One-cycle pulse: repeated START condition |
| wp | input | 1 | Write protect; high blocks the commit |
| tick | input | 1 | Timebase pulse for the program timer |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 12 | Array write address |
| arr_data | output | 8 | Array write data |
| busy | output | 1 | Program cycle in progress |
| last_ptr | output | 12 | Last loaded address, for current-address reads |

## Verification
A corrupted slot index or page register appears as a byte written to the wrong array address within the 32-clock scan. The bench finds it when it compares the array image as soon as `busy` falls. A lost or stale loaded-mask bit shows up as a wrong write count for that same cycle, or as a write that should not happen after a protected, discarded or empty command. A wrong controller state shows in `busy` one clock after STOP, or in a busy period of the wrong length. A wrong pointer value shows on `last_ptr` immediately after collection ends.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_PROG,
        ST_HOLD
    } pwb_state_e;
endpackage

// File: rtl/pwb_latch.sv
module pwb_latch #(
    parameter int PAGE = 32,
    parameter int DW   = 8,
    localparam int SW  = $clog2(PAGE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ld,
    input  logic [SW-1:0] ld_slot,
    input  logic [DW-1:0] ld_data,
    input  logic [SW-1:0] rd_slot,
    output logic [DW-1:0] rd_data,
    output logic [PAGE-1:0] loaded
);
    logic [DW-1:0] slot_q [PAGE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loaded <= '0;
            for (int i = 0; i < PAGE; i++) slot_q[i] <= '0;
        end else if (clr) begin
            loaded <= '0;
        end else if (ld) begin
            loaded[ld_slot] <= 1'b1;
            slot_q[ld_slot] <= ld_data;
        end
    end

    assign rd_data = slot_q[rd_slot];

    // later value of a slot replaces the earlier one
    assert_slot_loaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !clr) |=> (loaded[$past(ld_slot)] && slot_q[$past(ld_slot)] == $past(ld_data)));
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
    parameter int WR_TICKS = 5,
    localparam int CW = $clog2(WR_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    logic [CW-1:0] cnt_q;

    assign done = (cnt_q >= CW'(WR_TICKS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!run)       cnt_q <= '0;
        else if (tick && !done) cnt_q <= cnt_q + 1'b1;
    end

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(WR_TICKS));
endmodule

// File: rtl/pwb_page_writer.sv
module pwb_page_writer
    import pwb_pkg::*;
#(
    parameter int AW       = 12,
    parameter int DW       = 8,
    parameter int PAGE     = 32,
    parameter int WR_TICKS = 5,
    localparam int SW      = $clog2(PAGE),
    localparam int PW      = AW - SW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_start,
    input  logic [AW-1:0] wr_addr,
    input  logic          byte_vld,
    input  logic [DW-1:0] byte_data,
    input  logic          stop_evt,
    input  logic          restart_evt,
    input  logic          wp,
    input  logic          tick,
    output logic          arr_we,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_data,
    output logic          busy,
    output logic [AW-1:0] last_ptr
);
    pwb_state_e state_q, state_d;
    logic [PW-1:0]   page_q;
    logic [SW-1:0]   slot_q;
    logic [SW-1:0]   scan_q;
    logic [AW-1:0]   last_q;
    logic [AW-1:0]   ptr_q;
    logic [PAGE-1:0] loaded;
    logic [DW-1:0]   rd_data;
    logic            tmr_done;
    logic            accept;
    logic            ld;
    logic            fill_end;

    assign accept   = (state_q == ST_IDLE) && wr_start;
    assign ld       = (state_q == ST_FILL) && byte_vld && !stop_evt && !restart_evt;
    assign fill_end = (state_q == ST_FILL) && (stop_evt || restart_evt);

    pwb_latch #(.PAGE(PAGE), .DW(DW)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .ld      (ld),
        .ld_slot (slot_q),
        .ld_data (byte_data),
        .rd_slot (scan_q),
        .rd_data (rd_data),
        .loaded  (loaded)
    );

    pwb_timer #(.WR_TICKS(WR_TICKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick),
        .done  (tmr_done)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (wr_start) state_d = ST_FILL;
            ST_FILL: begin
                if (restart_evt)   state_d = ST_IDLE;
                else if (stop_evt) state_d = (|loaded && !wp) ? ST_PROG : ST_IDLE;
            end
            ST_PROG: if (scan_q == SW'(PAGE - 1)) state_d = ST_HOLD;
            ST_HOLD: if (tmr_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // address and pointer registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            slot_q <= '0;
            scan_q <= '0;
            last_q <= '0;
            ptr_q  <= '0;
        end else begin
            if (accept) begin
                page_q <= wr_addr[AW-1:SW];
                slot_q <= wr_addr[SW-1:0];
                last_q <= wr_addr - AW'(1);
            end
            if (ld) begin
                slot_q <= slot_q + 1'b1;
                last_q <= {page_q, slot_q};
            end
            if (fill_end) begin
                ptr_q  <= last_q;
                scan_q <= '0;
            end
            if (state_q == ST_PROG) scan_q <= scan_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q == ST_PROG) || (state_q == ST_HOLD);
        arr_we   = (state_q == ST_PROG) && loaded[scan_q];
        arr_addr = {page_q, scan_q};
        arr_data = rd_data;
        last_ptr = ptr_q;
    end

    assert_we_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);
    assert_page_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(page_q));
    assert_stop_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && stop_evt && !restart_evt && |loaded && !wp) |=> busy);
    assert_wp_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && stop_evt && wp) |=> !busy);
    assert_restart_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && restart_evt) |=> !busy);
    assert_busy_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tmr_done));
    assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(last_ptr));
endmodule

// File: tb/tb_pwb_page_writer.sv
module tb_pwb_page_writer;
    localparam int CLK_PERIOD = 10;
    localparam int WR_TICKS   = 6;
    localparam int TICK_DIV   = 8;

    logic clk = 0;
    logic rst_n = 0;
    logic wr_start = 0;
    logic [11:0] wr_addr = '0;
    logic byte_vld = 0;
    logic [7:0] byte_data = '0;
    logic stop_evt = 0;
    logic restart_evt = 0;
    logic wp = 0;
    logic tick = 0;
    logic arr_we;
    logic [11:0] arr_addr;
    logic [7:0] arr_data;
    logic busy;
    logic [11:0] last_ptr;

    int checks = 0;
    int errors = 0;
    int wr_total = 0;
    int tdiv = 0;
    bit done_flag = 0;

    byte unsigned mem_obs [4096];
    byte unsigned mem_exp [4096];

    pwb_page_writer #(.WR_TICKS(WR_TICKS)) dut (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .stop_evt(stop_evt),
        .restart_evt(restart_evt), .wp(wp), .tick(tick), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_data(arr_data), .busy(busy), .last_ptr(last_ptr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        tdiv = (tdiv + 1) % TICK_DIV;
        tick = (tdiv == 0);
    end

    // array model fed by the write strobe
    always @(negedge clk) begin
        if (rst_n && arr_we) begin
            mem_obs[arr_addr] = arr_data;
            wr_total = wr_total + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_ptr(input logic [11:0] a, input int n);
        logic [4:0] s;
        if (n == 0) return a - 12'd1;
        s = 5'(int'(a[4:0]) + n - 1);
        return {a[11:5], s};
    endfunction

    function automatic int mem_diff();
        int d = 0;
        for (int i = 0; i < 4096; i++) if (mem_obs[i] != mem_exp[i]) d++;
        return d;
    endfunction

    // mode: 0 = stop, 1 = restart; poke injects a command while busy
    task automatic do_write(input logic [11:0] a, input int n, input bit prot,
                            input bit mode, input bit poke, input string tag);
        byte unsigned pend [32];
        bit ld [32];
        int w0, nload, bc;
        logic [4:0] s;
        logic [11:0] ptr_before;
        for (int i = 0; i < 32; i++) ld[i] = 0;
        s = a[4:0];
        @(negedge clk);
        wr_start = 1; wr_addr = a;
        @(negedge clk);
        wr_start = 0;
        w0 = wr_total;
        for (int i = 0; i < n; i++) begin
            byte_vld = 1; byte_data = 8'($urandom);
            pend[s] = byte_data; ld[s] = 1; s = s + 5'd1;
            @(negedge clk);
            byte_vld = 0;
            if ($urandom % 3 == 0) @(negedge clk);
        end
        chk(wr_total == w0, {"R4 no write before stop ", tag}, wr_total, w0);
        wp = prot;
        if (mode) restart_evt = 1; else stop_evt = 1;
        @(negedge clk);
        restart_evt = 0; stop_evt = 0;
        wp = 0;
        nload = 0;
        for (int i = 0; i < 32; i++) if (ld[i]) nload++;
        if (!mode && !prot && n > 0) begin
            chk(busy == 1, {"R4 busy after stop ", tag}, busy, 1);
            chk(last_ptr == exp_ptr(a, n), {"R11 pointer ", tag}, last_ptr, exp_ptr(a, n));
            for (int i = 0; i < 32; i++) if (ld[i]) mem_exp[{a[11:5], 5'(i)}] = pend[i];
            bc = 0;
            if (poke) begin
                ptr_before = last_ptr;
                wr_start = 1; wr_addr = 12'h0F0;
                @(negedge clk); wr_start = 0; bc++;
                for (int i = 0; i < 3; i++) begin
                    byte_vld = 1; byte_data = 8'hEE;
                    @(negedge clk); byte_vld = 0; bc++;
                end
                stop_evt = 1; @(negedge clk); stop_evt = 0; bc++;
                chk(last_ptr == ptr_before, "R7 pointer unchanged by busy command", last_ptr, ptr_before);
            end
            while (busy && bc < 1000) begin @(negedge clk); bc++; end
            if (!poke)
                chk(bc >= 40 && bc <= 56, {"R6 busy length ", tag}, bc, WR_TICKS * TICK_DIV);
            chk(wr_total - w0 == nload, {"R5 write count ", tag}, wr_total - w0, nload);
            chk(mem_diff() == 0, {"R2 R3 R5 array image ", tag}, mem_diff(), 0);
            if (poke) begin
                repeat (60) @(negedge clk);
                chk(busy == 0 && wr_total - w0 == nload, "R7 busy-time command ignored", wr_total - w0, nload);
            end
        end else begin
            chk(busy == 0, {"R8 R9 R10 no busy ", tag}, busy, 0);
            chk(last_ptr == exp_ptr(a, n), {"R11 pointer ", tag}, last_ptr, exp_ptr(a, n));
            repeat (40) @(negedge clk);
            chk(wr_total == w0, {"R8 R9 R10 no write ", tag}, wr_total, w0);
            chk(mem_diff() == 0, {"R8 R9 R10 array kept ", tag}, mem_diff(), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        chk(busy == 0 && arr_we == 0 && last_ptr == 0, "R1 reset state", busy, 0);
        rst_n = 1;
        @(negedge clk);
        do_write(12'h123, 1, 0, 0, 0, "single byte");
        do_write(12'h45E, 5, 0, 0, 0, "page wrap R2");
        do_write(12'h800, 40, 0, 0, 0, "overflow R3");
        do_write(12'h300, 32, 0, 0, 0, "full page");
        do_write(12'h7A3, 4, 1, 0, 0, "protected R8");
        do_write(12'h222, 3, 0, 1, 0, "restart R9");
        do_write(12'h000, 0, 0, 1, 0, "restart no data R9");
        do_write(12'h555, 0, 0, 0, 0, "empty stop R10");
        do_write(12'hA10, 2, 0, 0, 1, "busy command R7");
        for (int k = 0; k < 20; k++) begin
            logic [11:0] ra;
            int rn;
            bit rp, rm;
            ra = 12'($urandom);
            rn = $urandom % 41;
            rp = ($urandom % 8) == 0;
            rm = ($urandom % 8) == 0;
            do_write(ra, rn, rp, rm, 0, "random");
        end
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule